// File: doc/BRIEF.md
# Frequency Code Selector with Watchdog Fallback

This block decides which 5-bit frequency code a clock generator runs with, and which PLL feedback (VCO) and reference divider values go with it. The code comes from strap pins sampled once after reset, or from a code written into a register. A divider-control bit can bypass the code and take the two dividers straight from programmed fields. Those fields use offset encodings: the VCO field is added to 8 and the reference field is added to 2.

A watchdog guards against an unstable, over-clocked setting. While it is enabled it counts down seconds from a programmed count. Software reloads it with a kick pulse. The one-second tick comes from a prescaler on the system clock, whose length is a parameter. When the count reaches zero, the watchdog raises a status flag and swaps in a stored safe code. That code then drives both the code output and the dividers, whatever mode was selected. The swap lasts until a software clear or a reset.

Top module: `freq_sel_wdog`

## Requirements
- R1: While `rstN` is low, `fsCode` reads 0 and `wdStatus` reads 0. At the first rising clock edge after reset is released, `strapCode` is captured. Later changes on `strapCode` do not affect `fsCode`.
- R2: When not tripped, `fsCode` equals `regCode` while `regSelect` is 1, and equals the captured strap code while `regSelect` is 0.
- R3: When `divDirect` is 0 and the watchdog is not tripped, the dividers follow the code: `vcoDiv` = 60 + 3*`fsCode` and `refDiv` = 4 + `fsCode[2:0]`.
- R4: When `divDirect` is 1 and the watchdog is not tripped, `vcoDiv` = `vcoField` + 8 (range 8 to 519) and `refDiv` = `refField` + 2 (range 2 to 129). `fsCode` is unaffected.
- R5: Suppose `wdEnable` is 1 and `wdCount` = N > 0, and a kick is sampled at edge k. With the tick length T cycles, `wdStatus` is still 0 after edge k+N*T and is 1 after edge k+N*T+1.
- R6: While `wdStatus` is 1, `fsCode` equals `safeCode`. The dividers then follow the R3 formulas applied to `safeCode`, even when `divDirect` is 1.
- R7: Once set, `wdStatus` stays 1, even through kicks, until a `wdClear` pulse. After the edge that samples the clear, `wdStatus` is 0 and the count is reloaded from `wdCount`.
- R8: While `wdEnable` is 0 the watchdog never trips. With `wdCount` = 0 and the watchdog enabled, it trips at the second edge after a clear.
- R9: A kick sampled before expiry reloads the count and restarts the tick phase, so expiry moves to N*T+1 edges after the latest kick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strapCode | input | 5 | Strap-pin frequency code, sampled once after reset |
| regSelect | input | 1 | 1: use the register-written code instead of the strap code |
| regCode | input | 5 | Register-written frequency code |
| divDirect | input | 1 | 1: dividers come from the direct divider fields |
| vcoField | input | 9 | Direct VCO divider field (divider minus 8) |
| refField | input | 7 | Direct reference divider field (divider minus 2) |
| wdEnable | input | 1 | Watchdog enable |
| wdCount | input | 8 | Watchdog timeout in seconds |
| wdKick | input | 1 | One-cycle reload pulse |
| wdClear | input | 1 | One-cycle pulse that clears the tripped state |
| safeCode | input | 5 | Fallback frequency code used after expiry |
| fsCode | output | 5 | Effective frequency code |
| vcoDiv | output | 10 | Effective VCO divider value |
| refDiv | output | 8 | Effective reference divider value |
| wdStatus | output | 1 | Watchdog expired flag |

## Verification
The assertions assume that `wdKick` and `wdClear` are single-cycle pulses that never occur together. They also assume that `wdCount` and `wdEnable` are held steady while a countdown is being timed. The stimulus changes these inputs only one nanosecond after a rising edge. It raises each pulse for exactly one edge and drops the enable only while the watchdog is idle. Inputs of the code and divider datapath are swept freely, because those paths are combinational from registered state.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  localparam int FS_W      = 5;
  localparam int VCO_FLD_W = 9;
  localparam int REF_FLD_W = 7;
  localparam int VCO_W     = VCO_FLD_W + 1;
  localparam int REF_W     = REF_FLD_W + 1;
  localparam int VCO_OFS   = 8;
  localparam int REF_OFS   = 2;
  localparam int TBL_VCO_BASE = 60;
  localparam int TBL_VCO_STEP = 3;
  localparam int TBL_REF_BASE = 4;

  typedef struct packed {
    logic tripped;
    logic useDirect;
    logic useReg;
  } fsw_strobe_t;

  function automatic logic [VCO_W-1:0] tblVco(input logic [FS_W-1:0] c);
    return VCO_W'(TBL_VCO_BASE) + VCO_W'(c) * VCO_W'(TBL_VCO_STEP);
  endfunction

  function automatic logic [REF_W-1:0] tblRef(input logic [FS_W-1:0] c);
    return REF_W'(TBL_REF_BASE) + REF_W'(c[2:0]);
  endfunction
endpackage

// File: rtl/fsw_ctrl.sv
module fsw_ctrl
  import fsw_pkg::*;
#(
  parameter int TICK_CYCLES = 100_000_000,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wdEnable,
  input  logic [CNT_W-1:0] wdCount,
  input  logic             wdKick,
  input  logic             wdClear,
  input  logic             regSelect,
  input  logic             divDirect,
  output fsw_strobe_t      strobe,
  output logic             wdStatus
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] PRESC_LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0]    presc;
  logic [CNT_W-1:0] secLeft;
  logic             tripped;
  logic             tick;

  assign tick = wdEnable && (presc == PRESC_LAST);

  // Second prescaler: restarts on kick, clear or while disabled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             presc <= '0;
    else if (wdClear || wdKick || !wdEnable) presc <= '0;
    else if (presc == PRESC_LAST)          presc <= '0;
    else                                   presc <= presc + 1'b1;
  end

  // Countdown of remaining seconds
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         secLeft <= '0;
    else if (wdClear || wdKick || !wdEnable) secLeft <= wdCount;
    else if (tick && secLeft != '0)    secLeft <= secLeft - 1'b1;
  end

  // Expiry flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        tripped <= 1'b0;
    else if (wdClear) tripped <= 1'b0;
    else if (wdEnable && secLeft == '0) tripped <= 1'b1;
  end

  always_comb begin
    strobe.tripped   = tripped;
    strobe.useDirect = divDirect;
    strobe.useReg    = regSelect;
  end
  assign wdStatus = tripped;

  // R5
  trip_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tripped) |-> $past(secLeft == '0 && wdEnable));

  // R7
  trip_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    tripped && !wdClear |=> tripped);

  // R9
  count_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdEnable && !wdKick && !wdClear |=> secLeft <= $past(secLeft));

  // R8
  disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wdEnable && !tripped |=> !tripped);
endmodule

// File: rtl/fsw_datapath.sv
module fsw_datapath
  import fsw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  fsw_strobe_t          strobe,
  input  logic [FS_W-1:0]      strapCode,
  input  logic [FS_W-1:0]      regCode,
  input  logic [FS_W-1:0]      safeCode,
  input  logic [VCO_FLD_W-1:0] vcoField,
  input  logic [REF_FLD_W-1:0] refField,
  output logic [FS_W-1:0]      fsCode,
  output logic [VCO_W-1:0]     vcoDiv,
  output logic [REF_W-1:0]     refDiv
);
  logic [FS_W-1:0] strapHeld;
  logic            strapTaken;

  // One-shot capture of the strap pins after reset release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapHeld  <= '0;
      strapTaken <= 1'b0;
    end else if (!strapTaken) begin
      strapHeld  <= strapCode;
      strapTaken <= 1'b1;
    end
  end

  logic [FS_W-1:0] selCode;
  always_comb begin
    selCode = strobe.useReg ? regCode : strapHeld;
    fsCode  = strobe.tripped ? safeCode : selCode;
    if (strobe.useDirect && !strobe.tripped) begin
      vcoDiv = VCO_W'(vcoField) + VCO_W'(VCO_OFS);
      refDiv = REF_W'(refField) + REF_W'(REF_OFS);
    end else begin
      vcoDiv = tblVco(fsCode);
      refDiv = tblRef(fsCode);
    end
  end

  // R1
  strap_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    strapTaken |=> $stable(strapHeld));

  // R6
  safe_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tripped |-> fsCode == safeCode && vcoDiv == tblVco(safeCode));
endmodule

// File: rtl/freq_sel_wdog.sv
module freq_sel_wdog
  import fsw_pkg::*;
#(
  parameter int TICK_CYCLES = 100_000_000,
  parameter int CNT_W       = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [FS_W-1:0]      strapCode,
  input  logic                 regSelect,
  input  logic [FS_W-1:0]      regCode,
  input  logic                 divDirect,
  input  logic [VCO_FLD_W-1:0] vcoField,
  input  logic [REF_FLD_W-1:0] refField,
  input  logic                 wdEnable,
  input  logic [CNT_W-1:0]     wdCount,
  input  logic                 wdKick,
  input  logic                 wdClear,
  input  logic [FS_W-1:0]      safeCode,
  output logic [FS_W-1:0]      fsCode,
  output logic [VCO_W-1:0]     vcoDiv,
  output logic [REF_W-1:0]     refDiv,
  output logic                 wdStatus
);
  fsw_strobe_t strobe;

  fsw_ctrl #(.TICK_CYCLES(TICK_CYCLES), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wdEnable(wdEnable), .wdCount(wdCount),
    .wdKick(wdKick), .wdClear(wdClear), .regSelect(regSelect),
    .divDirect(divDirect), .strobe(strobe), .wdStatus(wdStatus)
  );

  fsw_datapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .strapCode(strapCode),
    .regCode(regCode), .safeCode(safeCode), .vcoField(vcoField),
    .refField(refField), .fsCode(fsCode), .vcoDiv(vcoDiv), .refDiv(refDiv)
  );
endmodule

// File: tb/sim_freq_sel_wdog.sv
`timescale 1ns/1ps
module sim_freq_sel_wdog;
  localparam int T = 8;

  logic       clk = 1'b0;
  logic       rstN;
  logic [4:0] strapCode, regCode, safeCode;
  logic       regSelect, divDirect, wdEnable, wdKick, wdClear;
  logic [8:0] vcoField;
  logic [6:0] refField;
  logic [7:0] wdCount;
  logic [4:0] fsCode;
  logic [9:0] vcoDiv;
  logic [7:0] refDiv;
  logic       wdStatus;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  freq_sel_wdog #(.TICK_CYCLES(T), .CNT_W(8)) u0 (
    .clk(clk), .rstN(rstN), .strapCode(strapCode), .regSelect(regSelect),
    .regCode(regCode), .divDirect(divDirect), .vcoField(vcoField),
    .refField(refField), .wdEnable(wdEnable), .wdCount(wdCount),
    .wdKick(wdKick), .wdClear(wdClear), .safeCode(safeCode),
    .fsCode(fsCode), .vcoDiv(vcoDiv), .refDiv(refDiv), .wdStatus(wdStatus)
  );

  function automatic int expVco(int c); return 60 + 3 * c; endfunction
  function automatic int expRef(int c); return 4 + (c % 8); endfunction

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic pulseClear();
    wdClear = 1'b1; step(1); wdClear = 1'b0;
  endtask

  task automatic pulseKick();
    wdKick = 1'b1; step(1); wdKick = 1'b0;
  endtask

  initial begin
    #200us;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; strapCode = 5'h13; regCode = '0; safeCode = 5'h1B;
    regSelect = 0; divDirect = 0; wdEnable = 0; wdKick = 0; wdClear = 0;
    vcoField = '0; refField = '0; wdCount = 8'd3;
    step(3);
    chk("R1 reset fsCode", fsCode, 0);
    chk("R1 reset wdStatus", wdStatus, 0);
    rstN = 1'b1;
    step(1);
    chk("R1 strap capture", fsCode, 5'h13);
    strapCode = 5'h0A;
    step(2);
    chk("R1 strap change ignored", fsCode, 5'h13);
    chk("R3 strap vco", vcoDiv, expVco(5'h13));
    chk("R3 strap ref", refDiv, expRef(5'h13));

    // R2, R3 sweep of all register codes
    regSelect = 1'b1;
    for (int c = 0; c < 32; c++) begin
      regCode = 5'(c);
      #1;
      chk("R2 reg code", fsCode, c);
      chk("R3 table vco", vcoDiv, expVco(c));
      chk("R3 table ref", refDiv, expRef(c));
    end
    regSelect = 1'b0;
    #1;
    chk("R2 back to strap", fsCode, 5'h13);

    // R4 direct divider sweep
    divDirect = 1'b1;
    for (int r = 0; r < 128; r++) begin
      refField = 7'(r);
      vcoField = 9'((r * 37) % 512);
      #1;
      chk("R4 direct ref", refDiv, r + 2);
      chk("R4 direct vco", vcoDiv, ((r * 37) % 512) + 8);
      chk("R4 code unaffected", fsCode, 5'h13);
    end
    vcoField = 9'd0;   #1; chk("R4 vco min", vcoDiv, 8);
    vcoField = 9'd511; #1; chk("R4 vco max", vcoDiv, 519);
    vcoField = 9'd100; refField = 7'd5;

    // R8 disabled watchdog never trips
    wdEnable = 1'b0; wdCount = 8'd1;
    step(60);
    chk("R8 disabled no trip", wdStatus, 0);

    // R5, R6, R7 for several counts
    for (int n = 1; n <= 3; n++) begin
      wdCount = 8'(n); wdEnable = 1'b1;
      pulseClear();
      pulseKick();
      step(n * T);
      chk("R5 not yet expired", wdStatus, 0);
      chk("R4 direct before trip", vcoDiv, 108);
      step(1);
      chk("R5 expired", wdStatus, 1);
      chk("R6 safe code", fsCode, 5'h1B);
      chk("R6 safe vco", vcoDiv, expVco(5'h1B));
      chk("R6 safe ref", refDiv, expRef(5'h1B));
      pulseKick();
      step(20);
      chk("R7 holds through kick", wdStatus, 1);
      pulseClear();
      chk("R7 cleared", wdStatus, 0);
      chk("R7 code restored", fsCode, 5'h13);
    end

    // R9 kick postpones expiry
    wdCount = 8'd2;
    pulseClear();
    pulseKick();
    step(2 * T - 2);
    pulseKick();
    step(2);
    chk("R9 postponed", wdStatus, 0);
    step(2 * T - 2);
    chk("R9 not yet", wdStatus, 0);
    step(1);
    chk("R9 expired after reload", wdStatus, 1);

    // R8 zero count trips at second edge after clear
    wdCount = 8'd0;
    pulseClear();
    chk("R8 zero count after clear", wdStatus, 0);
    step(1);
    chk("R8 zero count trip", wdStatus, 1);

    wdEnable = 1'b0;
    pulseClear();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule